// File: doc/BRIEF.md
# Accelerator Streaming FIFO Bridge

This block sits on one DMA channel when that channel runs in its accelerator-streaming mode (mode code 4 of the channel's 3-bit mode field). The channel's internal buffering is bypassed. Each source element handed to the bridge goes straight out as a push into the accelerator's input FIFO. Before the push it is widened to 32 bits, by sign or by zeros as configured. On the return side the bridge pops results out of the accelerator's output FIFO, holds each one in a single-entry register and offers it to the destination write stream.

Software arms a job with a start pulse and a result count. Source elements flow in whenever the job is active and the accelerator's input FIFO is not full. The number of source elements is not counted, because the ratio of inputs to results belongs to the accelerator. The job ends once the configured number of results has been written to the destination. A one-cycle done pulse then follows. A chip instantiates one bridge per channel.

Top module: `hwfb_bridge`

## Requirements
- R1: While reset is asserted, srcReadyO, fifoPushO, fifoPopO, dstValidO, busyO and doneO are all 0.
- R2: While busy, srcReadyO equals NOT fifoFullI. fifoPushO is high in exactly the cycles in which srcValidI and srcReadyO are both high, so a source element is pushed in the cycle it is accepted.
- R3: fifoDataO carries the accepted source element widened to 32 bits. Width code 0 passes all 32 bits unchanged. Code 1 takes bits [15:0]. Codes 2 and 3 take bits [7:0]. The upper bits are copies of the element's top bit when cfgSignExtI is 1, and are zero when it is 0.
- R4: fifoPopO is high only in cycles where all of the following hold: the job is busy, fifoEmptyI is low, the result register is empty, no earlier pop is still waiting for its data, and fewer pops than the configured count have been issued.
- R5: At most one pop waits for its data at a time. The result is captured in the cycle fifoPushI is high, which may be the pop cycle itself or any later cycle. A fifoPushI pulse while no pop is waiting is ignored.
- R6: dstValidO rises in the cycle after a result is captured. dstDataO holds the captured word unchanged until a cycle in which dstReadyI is high.
- R7: A job with count N issues exactly N pops. busyO drops and doneO pulses for one cycle, in the cycle after the Nth destination write.
- R8: A start pulse while busy is ignored. A start pulse while idle with count 0 produces a done pulse in the next cycle, and no pops are issued and busy stays low.
- R9: While idle, srcReadyO, fifoPushO and fifoPopO stay low, whatever srcValidI and the FIFO flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | Start pulse for a job |
| countI | input | CNT_W | Number of results in the job |
| cfgWidthI | input | 2 | Source element width: 0 word, 1 half, 2 or 3 byte |
| cfgSignExtI | input | 1 | 1 extends by sign, 0 extends by zeros |
| busyO | output | 1 | Job active |
| doneO | output | 1 | One-cycle job completion pulse |
| srcValidI | input | 1 | Source element valid |
| srcDataI | input | DATA_W | Source element, right-aligned |
| srcReadyO | output | 1 | Source element accepted this cycle when valid |
| dstValidO | output | 1 | Destination write valid |
| dstDataO | output | DATA_W | Destination write data |
| dstReadyI | input | 1 | Destination accepts the write |
| fifoPopO | output | 1 | Pop request to the accelerator output FIFO |
| fifoPushO | output | 1 | Push into the accelerator input FIFO |
| fifoDataO | output | DATA_W | Widened data for the push |
| fifoEmptyI | input | 1 | Accelerator output FIFO empty |
| fifoFullI | input | 1 | Accelerator input FIFO full |
| fifoPushI | input | 1 | Popped result valid this cycle |
| fifoRespDataI | input | DATA_W | Popped result data |

## Verification
The bench builds the bridge with 32-bit data, so the half-word and byte widening paths have their natural 16- and 8-bit positions. The count is 8 bits wide, which keeps multi-result jobs and the zero-count start short. The accelerator model in the bench answers either in the pop cycle or one cycle later, so both capture timings of the result register are exercised. Stalls on full, empty and destination-not-ready occur in overlapping patterns, and these reach the case where a held result waits several cycles.

// File: rtl/hwfb_pkg.sv
package hwfb_pkg;

  typedef enum logic [1:0] {
    WIDTH_WORD = 2'd0,
    WIDTH_HALF = 2'd1,
    WIDTH_BYTE = 2'd2
  } elemWidth_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic takeResp;   // capture the accelerator result this cycle
    logic writeDone;  // destination accepted the held result
  } hwfbStrobe_t;

endpackage

// File: rtl/hwfb_datapath.sv
module hwfb_datapath
  import hwfb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  hwfbStrobe_t       strobeI,
  input  logic [1:0]        cfgWidthI,
  input  logic              cfgSignExtI,
  input  logic [DATA_W-1:0] srcDataI,
  input  logic [DATA_W-1:0] respDataI,
  output logic [DATA_W-1:0] pushDataO,
  output logic              holdFullO,
  output logic [DATA_W-1:0] holdDataO
);

  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;

  logic              holdFull;
  logic [DATA_W-1:0] holdData;

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] d,
                                               input logic [1:0] w,
                                               input logic sx);
    case (elemWidth_e'(w))
      WIDTH_WORD: return d;
      WIDTH_HALF: return {{(DATA_W-HALF_W){sx & d[HALF_W-1]}}, d[HALF_W-1:0]};
      default:    return {{(DATA_W-BYTE_W){sx & d[BYTE_W-1]}}, d[BYTE_W-1:0]};
    endcase
  endfunction

  assign pushDataO = widen(srcDataI, cfgWidthI, cfgSignExtI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
    end else if (strobeI.takeResp) begin
      holdFull <= 1'b1;
      holdData <= respDataI;
    end else if (strobeI.writeDone) begin
      holdFull <= 1'b0;
    end
  end

  assign holdFullO = holdFull;
  assign holdDataO = holdData;

  // R5: a capture never lands on a result that is still held
  p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobeI.takeResp |-> !holdFull);

  // R6: an unaccepted result stays put
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    holdFull && !strobeI.writeDone |=> holdFull && $stable(holdData));

endmodule

// File: rtl/hwfb_ctrl.sv
module hwfb_ctrl
  import hwfb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [CNT_W-1:0] countI,
  input  logic             srcValidI,
  input  logic             fifoFullI,
  input  logic             fifoEmptyI,
  input  logic             fifoPushI,
  input  logic             dstReadyI,
  input  logic             holdFullI,
  output hwfbStrobe_t      strobeO,
  output logic             srcReadyO,
  output logic             pushO,
  output logic             popO,
  output logic             busyO,
  output logic             doneO
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busy;
  logic             popPending;
  logic [CNT_W-1:0] popsLeft;
  logic [CNT_W-1:0] writesLeft;
  logic             popGo, takeResp, writeDone;
  logic             launch, zeroStart, lastWrite;

  always_comb begin
    popGo     = busy & ~fifoEmptyI & ~holdFullI & ~popPending & (popsLeft != '0);
    takeResp  = fifoPushI & (popPending | popGo);
    writeDone = holdFullI & dstReadyI;
    launch    = startI & ~busy & (countI != '0);
    zeroStart = startI & ~busy & (countI == '0);
    lastWrite = writeDone & (writesLeft == ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      popPending <= 1'b0;
      popsLeft   <= '0;
      writesLeft <= '0;
      doneO      <= 1'b0;
    end else begin
      doneO <= zeroStart | lastWrite;
      if (launch) begin
        busy       <= 1'b1;
        popPending <= 1'b0;
        popsLeft   <= countI;
        writesLeft <= countI;
      end else begin
        if (popGo)     popsLeft   <= popsLeft - ONE;
        if (writeDone) writesLeft <= writesLeft - ONE;
        if (lastWrite) busy       <= 1'b0;
        if (takeResp)   popPending <= 1'b0;
        else if (popGo) popPending <= 1'b1;
      end
    end
  end

  assign strobeO.takeResp  = takeResp;
  assign strobeO.writeDone = writeDone;
  assign srcReadyO = busy & ~fifoFullI;
  assign pushO     = busy & ~fifoFullI & srcValidI;
  assign popO      = popGo;
  assign busyO     = busy;

  // R4: every pop leaves either a waiting request or a captured result
  p_pop_claims_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    popO |=> (popPending || holdFullI));

  // R7: pops never run ahead of the writes still owed
  p_pop_budget_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> popsLeft <= writesLeft);

  // R7: leaving busy always comes with the done pulse
  p_end_signals_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneO);

endmodule

// File: rtl/hwfb_bridge.sv
module hwfb_bridge
  import hwfb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic [CNT_W-1:0]  countI,
  input  logic [1:0]        cfgWidthI,
  input  logic              cfgSignExtI,
  output logic              busyO,
  output logic              doneO,
  input  logic              srcValidI,
  input  logic [DATA_W-1:0] srcDataI,
  output logic              srcReadyO,
  output logic              dstValidO,
  output logic [DATA_W-1:0] dstDataO,
  input  logic              dstReadyI,
  output logic              fifoPopO,
  output logic              fifoPushO,
  output logic [DATA_W-1:0] fifoDataO,
  input  logic              fifoEmptyI,
  input  logic              fifoFullI,
  input  logic              fifoPushI,
  input  logic [DATA_W-1:0] fifoRespDataI
);

  hwfbStrobe_t strobe;
  logic        holdFull;

  hwfb_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startI     (startI),
    .countI     (countI),
    .srcValidI  (srcValidI),
    .fifoFullI  (fifoFullI),
    .fifoEmptyI (fifoEmptyI),
    .fifoPushI  (fifoPushI),
    .dstReadyI  (dstReadyI),
    .holdFullI  (holdFull),
    .strobeO    (strobe),
    .srcReadyO  (srcReadyO),
    .pushO      (fifoPushO),
    .popO       (fifoPopO),
    .busyO      (busyO),
    .doneO      (doneO)
  );

  hwfb_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobeI     (strobe),
    .cfgWidthI   (cfgWidthI),
    .cfgSignExtI (cfgSignExtI),
    .srcDataI    (srcDataI),
    .respDataI   (fifoRespDataI),
    .pushDataO   (fifoDataO),
    .holdFullO   (holdFull),
    .holdDataO   (dstDataO)
  );

  assign dstValidO = holdFull;

endmodule

// File: tb/hwfb_bridge_tb.sv
module hwfb_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int CW = 8;

  logic clk = 0;
  logic rstN = 0;
  logic startI = 0;
  logic [CW-1:0] countI = '0;
  logic [1:0] cfgWidthI = '0;
  logic cfgSignExtI = 0;
  logic busyO, doneO, srcReadyO, dstValidO, fifoPopO, fifoPushO;
  logic srcValidI = 0;
  logic [DW-1:0] srcDataI = '0;
  logic [DW-1:0] dstDataO, fifoDataO;
  logic dstReadyI = 1;
  logic fifoFullI = 0;
  logic fifoEmptyI, fifoPushI;
  logic [DW-1:0] fifoRespDataI;

  // accelerator model
  logic [DW-1:0] accQ[$];
  bit lat0 = 0;
  bit accEmpty = 1;
  bit accBlock = 0;
  logic [DW-1:0] accHead = '0;
  logic pushD = 0;
  logic [DW-1:0] dataD = '0;
  bit sawPop = 0;
  logic strayPush = 0;
  logic [DW-1:0] strayData = '0;

  assign fifoEmptyI = accEmpty | accBlock;
  assign fifoPushI = lat0 ? fifoPopO : (pushD | strayPush);
  assign fifoRespDataI = lat0 ? accHead : (strayPush ? strayData : dataD);

  hwfb_bridge #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .countI(countI),
    .cfgWidthI(cfgWidthI), .cfgSignExtI(cfgSignExtI),
    .busyO(busyO), .doneO(doneO),
    .srcValidI(srcValidI), .srcDataI(srcDataI), .srcReadyO(srcReadyO),
    .dstValidO(dstValidO), .dstDataO(dstDataO), .dstReadyI(dstReadyI),
    .fifoPopO(fifoPopO), .fifoPushO(fifoPushO), .fifoDataO(fifoDataO),
    .fifoEmptyI(fifoEmptyI), .fifoFullI(fifoFullI), .fifoPushI(fifoPushI),
    .fifoRespDataI(fifoRespDataI)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] widenRef(input logic [DW-1:0] d,
                                             input int w, input bit sx);
    logic [DW-1:0] r;
    if (w == 0) r = d;
    else if (w == 1) r = (sx && d[15]) ? {16'hFFFF, d[15:0]} : {16'h0, d[15:0]};
    else r = (sx && d[7]) ? {24'hFF_FFFF, d[7:0]} : {24'h0, d[7:0]};
    return r;
  endfunction

  // behavioural reference model, stepped at each falling edge
  bit mBusy, mPend, mHold, mDone;
  int mPops, mWrites;
  logic [DW-1:0] mHoldData;
  int popCount = 0;
  bit gotDone = 0;

  always @(negedge clk) begin
    bit srcRdyE, pushE, popE, takeE, wrE;
    if (!rstN) begin
      mBusy = 0; mPend = 0; mHold = 0; mDone = 0; mPops = 0; mWrites = 0;
      mHoldData = '0;
      chk("R1", "reset srcReady", srcReadyO, 0);
      chk("R1", "reset push", fifoPushO, 0);
      chk("R1", "reset pop", fifoPopO, 0);
      chk("R1", "reset dstValid", dstValidO, 0);
      chk("R1", "reset busy", busyO, 0);
      chk("R1", "reset done", doneO, 0);
      sawPop = 0;
    end else begin
      srcRdyE = mBusy && !fifoFullI;
      pushE = srcRdyE && srcValidI;
      popE = mBusy && !fifoEmptyI && !mHold && !mPend && (mPops > 0);
      chk(mBusy ? "R2" : "R9", "srcReady", srcReadyO, srcRdyE);
      chk(mBusy ? "R2" : "R9", "push", fifoPushO, pushE);
      if (pushE) chk("R3", "push data", fifoDataO, widenRef(srcDataI, cfgWidthI, cfgSignExtI));
      chk(mBusy ? "R4" : "R9", "pop", fifoPopO, popE);
      chk("R6", "dstValid", dstValidO, mHold);
      if (mHold) chk("R6", "dstData", dstDataO, mHoldData);
      chk("R7", "done", doneO, mDone);
      chk("R7", "busy", busyO, mBusy);
      if (fifoPopO) popCount++;
      if (doneO) gotDone = 1;
      sawPop = fifoPopO;
      takeE = fifoPushI && (mPend || popE);
      wrE = mHold && dstReadyI;
      mDone = (startI && !mBusy && countI == 0) || (wrE && mWrites == 1);
      if (!mBusy && startI && countI != 0) begin
        mBusy = 1; mPops = countI; mWrites = countI; mPend = 0;
      end else begin
        if (popE) mPops--;
        if (wrE) begin
          mWrites--;
          if (mWrites == 0) mBusy = 0;
        end
        if (takeE) mPend = 0;
        else if (popE) mPend = 1;
      end
      if (takeE) begin mHold = 1; mHoldData = fifoRespDataI; end
      else if (wrE) mHold = 0;
    end
  end

  // accelerator reacts just after each rising edge
  always @(posedge clk) begin
    logic [DW-1:0] tmp;
    #1;
    pushD = 0;
    if (sawPop && accQ.size() > 0) begin
      tmp = accQ.pop_front();
      if (!lat0) begin pushD = 1; dataD = tmp; end
    end
    accEmpty = (accQ.size() == 0);
    accHead = accEmpty ? '0 : accQ[0];
  end

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] nextRng(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic runJob(input int w, input bit sx, input int n, input bit l0,
                        input bit stallDst, input int restartAt);
    cfgWidthI = w[1:0]; cfgSignExtI = sx; lat0 = l0;
    for (int i = 0; i < n; i++) accQ.push_back(32'h8000_0000 ^ (i * 32'h0101_9E37) ^ {24'h0, 8'(w * 16 + i)});
    accEmpty = 0; accHead = accQ[0];
    popCount = 0; gotDone = 0;
    startI = 1; countI = CW'(n);
    tick();
    startI = 0;
    for (int cyc = 0; cyc < 400 && !gotDone; cyc++) begin
      rng = nextRng(rng);
      srcValidI = rng[0] | rng[3];
      srcDataI = rng;
      fifoFullI = (cyc % 5 == 3);
      dstReadyI = stallDst ? (cyc % 3 != 0) : 1'b1;
      accBlock = (cyc % 7 == 2);
      startI = (cyc == restartAt && restartAt > 0);
      countI = startI ? CW'(3) : CW'(n);
      tick();
      if (cyc == restartAt && restartAt > 0) begin
        @(negedge clk);
        chk("R8", "busy after start while busy", busyO, 1);
        tick();
      end
    end
    startI = 0; srcValidI = 0; fifoFullI = 0; dstReadyI = 1; accBlock = 0;
    @(negedge clk);
    chk("R7", "done observed", gotDone, 1);
    chk("R7", "pop count", popCount, n);
    if (restartAt > 0) chk("R8", "pops unchanged by restart", popCount, n);
    chk("R7", "busy after job", busyO, 0);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // idle: source and flags do nothing
    srcValidI = 1; accQ.push_back(32'h55); accEmpty = 0; accHead = 32'h55;
    repeat (2) tick();
    @(negedge clk);
    chk("R9", "idle no pop", fifoPopO, 0);
    chk("R9", "idle no push", fifoPushO, 0);
    srcValidI = 0; void'(accQ.pop_front()); accEmpty = 1; accHead = '0;
    tick();

    runJob(0, 0, 4, 0, 0, 0);
    runJob(1, 1, 3, 1, 1, 0);
    runJob(1, 0, 3, 0, 1, 0);
    runJob(2, 1, 5, 0, 0, 6);
    runJob(2, 0, 2, 1, 1, 0);
    runJob(3, 1, 2, 0, 0, 0);
    runJob(0, 1, 6, 1, 1, 0);

    // zero count start
    popCount = 0;
    startI = 1; countI = '0;
    tick();
    startI = 0;
    @(negedge clk);
    chk("R8", "zero count done", doneO, 1);
    chk("R8", "zero count not busy", busyO, 0);
    tick();
    chk("R8", "zero count pops", popCount, 0);

    // stray result pulse while nothing is waiting
    lat0 = 0; strayData = 32'hDEAD_BEEF; strayPush = 1;
    tick();
    strayPush = 0;
    @(negedge clk);
    chk("R5", "stray result ignored", dstValidO, 0);
    tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule